// File: doc/BRIEF.md
# Vibration Pattern Sequencer

This block drives a single motor-enable line with one of three fixed on/off rhythms. Three request buttons choose the rhythm: one gives a pulse train of three bursts, one gives two bursts, one gives a single burst. Each burst rhythm opens with a long on-interval. The trains with more than one burst end on a shorter on-interval. Every on-interval is followed by an off-interval. All interval lengths are counted in pulses of a millisecond tick input, so a faster tick compresses the whole rhythm.

The buttons are asynchronous to the clock. They pass through two-stage synchronisers and are sampled only while no rhythm is running. Once a rhythm starts it runs to its end whatever the buttons do. After the last off-interval the block is idle for one cycle and then samples the buttons again. A button that is still held therefore starts a new rhythm straight away.

Top module: `vib_pattern_seq`

## Requirements
- R1: The three-burst rhythm is on 600, off 300, on 300, off 300, on 150, off 300 tick pulses.
- R2: The two-burst rhythm is on 600, off 300, on 150, off 300 tick pulses.
- R3: The one-burst rhythm is on 600, off 300 tick pulses.
- R4: When several buttons are sampled high together, `btn_triple` wins over `btn_double`, and `btn_double` wins over `btn_single`.
- R5: `motor_en` is low whenever `busy` is low, including during reset and right after it. Both outputs are low out of reset.
- R6: Once a rhythm has started, button activity does not change its interval lengths or its length in segments.
- R7: A segment advances only on clock edges where `tick_ms` is high. A segment of N ticks ends on the Nth tick edge after it began, and cycles without a tick leave the rhythm where it is.
- R8: `busy` is high from the first on-interval until the end of the last off-interval, and every rhythm begins with `motor_en` high. If a button is still held, a new rhythm starts after exactly one idle cycle.
- R9: A button raised before clock edge k is seen through two synchroniser stages, so `busy` and `motor_en` rise after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | Millisecond tick, high for one clock per tick |
| btn_triple | input | 1 | Request for the three-burst rhythm (asynchronous) |
| btn_double | input | 1 | Request for the two-burst rhythm (asynchronous) |
| btn_single | input | 1 | Request for the one-burst rhythm (asynchronous) |
| motor_en | output | 1 | Registered motor enable |
| busy | output | 1 | High while a rhythm is running |

## Verification
The embedded properties assume three things about the inputs. Reset is applied before the first edge of interest. `tick_ms` is a clean synchronous level that is sampled only at rising edges. The buttons need no debouncing beyond the synchronisers. The bench drives every input on the falling clock edge. It generates the tick from a divider, either every cycle or every second cycle. It only toggles buttons as whole-cycle levels, so each sampled value is unambiguous. Because the start of the first segment need not line up with a tick under the slower divider, the bench allows one cycle less on the opening interval there and expects exact lengths everywhere else.

// File: rtl/vib_pkg.sv
package vib_pkg;

  typedef enum logic [1:0] {
    PAT_NONE   = 2'd0,
    PAT_SINGLE = 2'd1,
    PAT_DOUBLE = 2'd2,
    PAT_TRIPLE = 2'd3
  } pat_e;

  localparam int unsigned SEG_W = 3;

  function automatic logic [SEG_W-1:0] seg_total(input pat_e p);
    case (p)
      PAT_TRIPLE: seg_total = SEG_W'(6);
      PAT_DOUBLE: seg_total = SEG_W'(4);
      PAT_SINGLE: seg_total = SEG_W'(2);
      default:    seg_total = SEG_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/vib_sync.sv
module vib_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/vib_pick.sv
module vib_pick
  import vib_pkg::*;
(
  input  logic [2:0] req_i,   // {triple, double, single}
  output pat_e       pat_o
);
  always_comb begin
    if (req_i[2])      pat_o = PAT_TRIPLE;
    else if (req_i[1]) pat_o = PAT_DOUBLE;
    else if (req_i[0]) pat_o = PAT_SINGLE;
    else               pat_o = PAT_NONE;
  end
endmodule

// File: rtl/vib_seg_table.sv
module vib_seg_table
  import vib_pkg::*;
#(
  parameter int unsigned LONG_T  = 600,
  parameter int unsigned MID_T   = 300,
  parameter int unsigned SHORT_T = 150,
  parameter int unsigned GAP_T   = 300,
  parameter int unsigned LEN_W   = 10
) (
  input  pat_e             pat_i,
  input  logic [SEG_W-1:0] idx_i,
  output logic [LEN_W-1:0] len_o,
  output logic             last_o
);
  always_comb begin
    len_o = LEN_W'(GAP_T);
    if (!idx_i[0]) begin
      if (idx_i == '0)                                 len_o = LEN_W'(LONG_T);
      else if (pat_i == PAT_TRIPLE && idx_i == SEG_W'(2)) len_o = LEN_W'(MID_T);
      else                                             len_o = LEN_W'(SHORT_T);
    end
  end

  assign last_o = (idx_i == seg_total(pat_i) - SEG_W'(1));
endmodule

// File: rtl/vib_seg_timer.sv
module vib_seg_timer #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == len_i - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (run_i && tick_i)  cnt_q <= done_o ? '0 : cnt_q + LEN_W'(1);
  end

  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i && !clr_i) |=> $stable(cnt_q));

  a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < len_i));
endmodule

// File: rtl/vib_pattern_seq.sv
module vib_pattern_seq
  import vib_pkg::*;
#(
  parameter int unsigned LONG_T  = 600,
  parameter int unsigned MID_T   = 300,
  parameter int unsigned SHORT_T = 150,
  parameter int unsigned GAP_T   = 300,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic btn_triple,
  input  logic btn_double,
  input  logic btn_single,
  output logic motor_en,
  output logic busy
);
  localparam int unsigned MAX_A   = (LONG_T > MID_T) ? LONG_T : MID_T;
  localparam int unsigned MAX_B   = (SHORT_T > GAP_T) ? SHORT_T : GAP_T;
  localparam int unsigned MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

  logic [2:0]       req_s;
  pat_e             pick;
  pat_e             pat_q;
  logic [SEG_W-1:0] seg_q;
  logic             busy_q, motor_q;
  logic [LEN_W-1:0] seg_len;
  logic             seg_last, seg_done, start;

  vib_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({btn_triple, btn_double, btn_single}),
    .q_o   (req_s)
  );

  vib_pick u_pick (
    .req_i (req_s),
    .pat_o (pick)
  );

  vib_seg_table #(
    .LONG_T(LONG_T), .MID_T(MID_T), .SHORT_T(SHORT_T), .GAP_T(GAP_T), .LEN_W(LEN_W)
  ) u_table (
    .pat_i  (pat_q),
    .idx_i  (seg_q),
    .len_o  (seg_len),
    .last_o (seg_last)
  );

  assign start = !busy_q && (pick != PAT_NONE);

  vib_seg_timer #(.LEN_W(LEN_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start),
    .run_i  (busy_q),
    .tick_i (tick_ms),
    .len_i  (seg_len),
    .done_o (seg_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      motor_q <= 1'b0;
      pat_q   <= PAT_NONE;
      seg_q   <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      motor_q <= 1'b1;
      pat_q   <= pick;
      seg_q   <= '0;
    end else if (busy_q && seg_done) begin
      if (seg_last) begin
        busy_q  <= 1'b0;
        motor_q <= 1'b0;
        pat_q   <= PAT_NONE;
        seg_q   <= '0;
      end else begin
        seg_q   <= seg_q + SEG_W'(1);
        motor_q <= seg_q[0];   // next index even -> on
      end
    end
  end

  assign busy     = busy_q;
  assign motor_en = motor_q;

  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !motor_q);

  a_r6_pattern_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(pat_q));

  a_r8_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> motor_q);

  a_r1_level_parity: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (motor_q == !seg_q[0]));

  a_r6_seg_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (seg_q < seg_total(pat_q)));
endmodule

// File: tb/vib_pattern_seq_tb.sv
module vib_pattern_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  // {btn[2:0] = {triple,double,single}, div[1:0], nseg[2:0], d0..d5 (10b each)}
  localparam logic [67:0] VEC [NVEC] = '{
    {3'b100, 2'd1, 3'd6, 10'd600, 10'd300, 10'd300, 10'd300, 10'd150, 10'd300}, // R1
    {3'b010, 2'd1, 3'd4, 10'd600, 10'd300, 10'd150, 10'd300, 10'd0,   10'd0  }, // R2
    {3'b001, 2'd1, 3'd2, 10'd600, 10'd300, 10'd0,   10'd0,   10'd0,   10'd0  }, // R3
    {3'b111, 2'd1, 3'd6, 10'd600, 10'd300, 10'd300, 10'd300, 10'd150, 10'd300}, // R4
    {3'b011, 2'd1, 3'd4, 10'd600, 10'd300, 10'd150, 10'd300, 10'd0,   10'd0  }, // R4
    {3'b110, 2'd2, 3'd6, 10'd600, 10'd300, 10'd300, 10'd300, 10'd150, 10'd300}, // R7
    {3'b001, 2'd2, 3'd2, 10'd600, 10'd300, 10'd0,   10'd0,   10'd0,   10'd0  }  // R7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic btn_triple = 1'b0, btn_double = 1'b0, btn_single = 1'b0;
  logic motor_en, busy;

  int n_run = 0, n_fail = 0;
  int tick_div = 1, tick_ph = 0;
  bit finished = 1'b0;

  vib_pattern_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .btn_triple(btn_triple), .btn_double(btn_double), .btn_single(btn_single),
    .motor_en(motor_en), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_ms = (tick_ph == 0);
    tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_btn(input logic [2:0] b);
    {btn_triple, btn_double, btn_single} = b;
  endtask

  task automatic wait_busy(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
  endtask

  task automatic run_vec(input int v);
    logic [2:0] b;
    int div, nseg, d, cnt, tot;
    bit seen, lvl;
    string req;
    b    = VEC[v][67:65];
    div  = int'(VEC[v][64:63]);
    nseg = int'(VEC[v][62:60]);
    req  = (v < 3) ? $sformatf("R%0d", v + 1) : ((v < 5) ? "R4" : "R7");
    @(negedge clk);
    tick_div = div;
    tick_ph  = 0;
    set_btn(b);
    wait_busy(seen);
    check(seen, req, int'(busy), 1);
    set_btn(~b);                       // R6: disturb buttons during the run
    tot = 0;
    for (int s = 0; s < nseg; s++) begin
      d   = int'(VEC[v][59 - 10*s -: 10]);
      lvl = (s % 2 == 0);
      cnt = 0;
      while (busy && motor_en == lvl && cnt < 5000) begin
        cnt++; tot++;
        if (tot == 100) set_btn(3'b000);
        @(negedge clk);
      end
      if (s == 0 && div > 1)
        check(cnt <= d*div && cnt >= d*div - (div-1), {req, " R6 seg0"}, cnt, d*div);
      else
        check(cnt == d*div, $sformatf("%s R6 seg%0d", req, s), cnt, d*div);
    end
    check(!busy && !motor_en, "R8 end idle", int'({busy, motor_en}), 0);
    repeat (8) @(negedge clk);
    check(!busy && !motor_en, "R5 stays idle", int'({busy, motor_en}), 0);
  endtask

  initial begin
    bit seen;
    int gap;
    // reset state (R5)
    repeat (3) @(negedge clk);
    check(!busy && !motor_en, "R5 in reset", int'({busy, motor_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !motor_en, "R5 after reset", int'({busy, motor_en}), 0);

    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R9: latency through two synchroniser stages
    tick_div = 1;
    @(negedge clk);
    set_btn(3'b001);
    @(negedge clk);   // after edge k
    check(!busy, "R9 edge k", int'(busy), 0);
    @(negedge clk);   // after edge k+1
    check(!busy && !motor_en, "R9 edge k+1", int'(busy), 0);
    @(negedge clk);   // after edge k+2
    check(busy && motor_en, "R9 edge k+2", int'({busy, motor_en}), 3);

    // R8: held button retriggers after one idle cycle
    while (busy) @(negedge clk);
    gap = 0;
    while (!busy && gap < 50) begin gap++; @(negedge clk); end
    check(gap == 1, "R8 retrigger gap", gap, 1);
    check(motor_en, "R8 restart high", int'(motor_en), 1);
    set_btn(3'b000);
    while (busy) @(negedge clk);

    // R7: tick withheld freezes the segment
    set_btn(3'b001);
    wait_busy(seen);
    set_btn(3'b000);
    repeat (10) @(negedge clk);
    tick_div = 3'd0 + 1000;           // very sparse ticks
    tick_ph = 1;
    repeat (200) @(negedge clk);
    check(busy && motor_en, "R7 frozen without tick", int'({busy, motor_en}), 3);
    tick_div = 1;
    tick_ph = 0;

    // R5: reset mid-pattern
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !motor_en, "R5 reset mid-run", int'({busy, motor_en}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy && !motor_en, "R5 idle after reset", int'({busy, motor_en}), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule